// File: doc/BRIEF.md
# Multiplexed-Bus Register and Alarm Interrupt Interface

This block is the configuration and status port of a receive line-processing chip. A host processor reaches it over an 8-bit bus with an address latch enable, so the same pins can carry address and data in turn. The block holds two control bytes and an interrupt mask. It keeps a sticky status bit for each of five receive alarm sources, and it pulls an open-drain interrupt line low while any unmasked status bit is set.

The host strobes are sampled on the system clock `clk`, so they are expected to be slow relative to it. A write takes effect when the write strobe returns high while chip select is still low. A read of the status byte clears it when the read strobe returns high, so the host sees the value before it is cleared. The five alarm levels are also ORed together and registered on the receive clock `rx_clk` to form a single receive alarm pin.

The data bus is modelled as separate input, output and output-enable signals. The open-drain interrupt is modelled as a pull-down enable.

Top module: `mpbus_alarm_if`

## Requirements
- R1: While `ale` is high, the register address follows `addr` with no clock needed. While `ale` is low, the address is the value `addr` had at the last `clk` edge on which `ale` was high.
- R2: `d_oe` is 1 only while both `cs_n` and `rd_n` are low. While it is 1, `d_out` carries the addressed register.
- R3: A write happens on the first `clk` edge at which `wr_n` is seen high after being low, provided `cs_n` is low at that edge. It stores `d_in` into the addressed register. Toggling `wr_n` while `cs_n` is high changes nothing.
- R4: The register map is as follows. 0x00 and 0x01 are 8-bit read/write control bytes. 0x02 is the alarm status byte. 0x03 is the read/write mask; only bits [4:0] are kept and bits [7:5] read 0. 0x04 is read-only and returns the present alarm levels in bits [4:0].
- R5: `alm_in` bit positions are: 0 line AIS, 1 path AIS, 2 loss of signal, 3 loss of frame, 4 loss of cell delineation. A status bit sets on a rising edge of its source seen at `clk`. It then stays set while the source stays high or falls.
- R6: A read of 0x02 returns the status and clears all of it when `rd_n` rises with `cs_n` low. If a source rises on that same edge, its bit stays set after the clear.
- R7: `irq_pull` is 1 while any status bit is set whose mask bit is 1. Changing the mask to exclude that bit releases it.
- R8: `rx_alarm` is the OR of all five `alm_in` bits, captured on each rising edge of `rx_clk`. It does not change between those edges.
- R9: Reading any address other than 0x00 to 0x04 returns 0x00, and writing to one changes no register.
- R10: After reset all registers and the status are 0, and `d_oe`, `irq_pull` and `rx_alarm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus strobes and alarm sources |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per clock |
| rx_clk | input | 1 | Receive clock for the combined alarm output |
| ale | input | 1 | Address latch enable: transparent when high, holds when low |
| addr | input | 8 | Register address |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| d_in | input | 8 | Write data from the host |
| d_out | output | 8 | Read data to the host |
| d_oe | output | 1 | Data bus drive enable |
| irq_pull | output | 1 | Open-drain interrupt: 1 pulls the line low |
| alm_in | input | 5 | Receive alarm source levels |
| rx_alarm | output | 1 | Combined receive alarm, registered on `rx_clk` |

## Verification
The hardest case to reach is the clearing read whose `rd_n` rising edge lands on the same `clk` edge as a new alarm rising edge. The bench first sets a different status bit. It then opens a read of 0x02, and on the single negative edge where it releases `rd_n` it also raises the source of another bit. The status read afterwards must hold only the new bit. The address-hold case is reached by changing `addr` to an unimplemented address right after `ale` falls in every table access, so a leaky latch would read zero or write nowhere.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;
  // register offsets
  localparam int unsigned REG_CTRL0 = 0;
  localparam int unsigned REG_CTRL1 = 1;
  localparam int unsigned REG_STAT  = 2;
  localparam int unsigned REG_MASK  = 3;
  localparam int unsigned REG_LIVE  = 4;
endpackage

// File: rtl/mpbus_rst_sync.sv
module mpbus_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mpbus_bus_front.sv
module mpbus_bus_front #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          ale,
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic [AW-1:0] eff_addr,
  output logic          wr_evt,
  output logic          rd_evt
);
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic          rd_q;

  // transparent while ale high, held value otherwise
  always_comb eff_addr = ale ? addr : addr_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b1;
      rd_q   <= 1'b1;
    end else begin
      if (ale) addr_q <= addr;
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  // strobe trailing edges qualified by chip select
  always_comb begin
    wr_evt = wr_n & ~wr_q & ~cs_n;
    rd_evt = rd_n & ~rd_q & ~cs_n;
  end
endmodule

// File: rtl/mpbus_alarm_status.sv
module mpbus_alarm_status #(
  parameter int unsigned NALM = 5
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic [NALM-1:0] alm_in,
  input  logic            clr,
  input  logic [NALM-1:0] mask,
  output logic [NALM-1:0] stat,
  output logic            irq
);
  logic [NALM-1:0] alm_q;
  logic [NALM-1:0] stat_q;
  logic [NALM-1:0] stat_d;
  logic [NALM-1:0] set_v;

  // per-bit edge detect and sticky next state; a set beats a clear
  for (genvar i = 0; i < NALM; i++) begin : g_bit
    always_comb begin
      set_v[i]  = alm_in[i] & ~alm_q[i];
      stat_d[i] = (stat_q[i] & ~clr) | set_v[i];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      alm_q  <= '0;
      stat_q <= '0;
    end else begin
      alm_q  <= alm_in;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & mask);
endmodule

// File: rtl/mpbus_rx_alarm.sv
module mpbus_rx_alarm #(
  parameter int unsigned NALM = 5
) (
  input  logic            rx_clk,
  input  logic            rx_srst_n,
  input  logic [NALM-1:0] alm_in,
  output logic            rx_alarm
);
  logic alm_d;

  always_comb alm_d = |alm_in;

  always_ff @(posedge rx_clk or negedge rx_srst_n) begin
    if (!rx_srst_n) rx_alarm <= 1'b0;
    else            rx_alarm <= alm_d;
  end
endmodule

// File: rtl/mpbus_alarm_if.sv
module mpbus_alarm_if
  import mpbus_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NALM = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_clk,
  input  logic            ale,
  input  logic [AW-1:0]   addr,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [DW-1:0]   d_in,
  output logic [DW-1:0]   d_out,
  output logic            d_oe,
  output logic            irq_pull,
  input  logic [NALM-1:0] alm_in,
  output logic            rx_alarm
);
  localparam logic [AW-1:0] A_CTRL0 = AW'(REG_CTRL0);
  localparam logic [AW-1:0] A_CTRL1 = AW'(REG_CTRL1);
  localparam logic [AW-1:0] A_STAT  = AW'(REG_STAT);
  localparam logic [AW-1:0] A_MASK  = AW'(REG_MASK);
  localparam logic [AW-1:0] A_LIVE  = AW'(REG_LIVE);

  logic            srst_n;
  logic            rx_srst_n;
  logic [AW-1:0]   eff_addr;
  logic            wr_evt;
  logic            rd_evt;
  logic [DW-1:0]   ctrl0_q, ctrl0_d;
  logic [DW-1:0]   ctrl1_q, ctrl1_d;
  logic [NALM-1:0] mask_q, mask_d;
  logic [NALM-1:0] stat;
  logic            stat_clr;
  logic [DW-1:0]   rd_val;

  mpbus_rst_sync u_rst_sys (.clk(clk),    .arst_n(rst_n), .srst_n(srst_n));
  mpbus_rst_sync u_rst_rx  (.clk(rx_clk), .arst_n(rst_n), .srst_n(rx_srst_n));

  mpbus_bus_front #(.AW(AW)) u_front (
    .clk(clk), .srst_n(srst_n), .ale(ale), .addr(addr),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .eff_addr(eff_addr), .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  always_comb stat_clr = rd_evt & (eff_addr == A_STAT);

  mpbus_alarm_status #(.NALM(NALM)) u_status (
    .clk(clk), .srst_n(srst_n), .alm_in(alm_in), .clr(stat_clr),
    .mask(mask_q), .stat(stat), .irq(irq_pull)
  );

  mpbus_rx_alarm #(.NALM(NALM)) u_rxalm (
    .rx_clk(rx_clk), .rx_srst_n(rx_srst_n), .alm_in(alm_in), .rx_alarm(rx_alarm)
  );

  // register file next state
  always_comb begin
    ctrl0_d = ctrl0_q;
    ctrl1_d = ctrl1_q;
    mask_d  = mask_q;
    if (wr_evt) begin
      case (eff_addr)
        A_CTRL0: ctrl0_d = d_in;
        A_CTRL1: ctrl1_d = d_in;
        A_MASK:  mask_d  = d_in[NALM-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      mask_q  <= '0;
    end else begin
      ctrl0_q <= ctrl0_d;
      ctrl1_q <= ctrl1_d;
      mask_q  <= mask_d;
    end
  end

  // read path
  always_comb begin
    case (eff_addr)
      A_CTRL0: rd_val = ctrl0_q;
      A_CTRL1: rd_val = ctrl1_q;
      A_STAT:  rd_val = DW'(stat);
      A_MASK:  rd_val = DW'(mask_q);
      A_LIVE:  rd_val = DW'(alm_in);
      default: rd_val = '0;
    endcase
  end

  always_comb begin
    d_oe  = ~cs_n & ~rd_n;
    d_out = d_oe ? rd_val : '0;
  end
endmodule

// File: rtl/mpbus_alarm_chk.sv
module mpbus_alarm_chk #(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NALM = 5
) (
  input logic            clk,
  input logic            srst_n,
  input logic            rx_clk,
  input logic            rx_srst_n,
  input logic            ale,
  input logic [AW-1:0]   eff_addr,
  input logic            cs_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic [DW-1:0]   d_in,
  input logic [NALM-1:0] alm_in,
  input logic [NALM-1:0] stat,
  input logic [DW-1:0]   ctrl0_q,
  input logic            irq_pull,
  input logic            rx_alarm
);
  logic            wr_c, rd_c, rx_armed;
  logic [NALM-1:0] alm_c;
  logic            wr_rise, rd_rise;
  logic [NALM-1:0] alm_rise;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wr_c  <= 1'b1;
      rd_c  <= 1'b1;
      alm_c <= '0;
    end else begin
      wr_c  <= wr_n;
      rd_c  <= rd_n;
      alm_c <= alm_in;
    end
  end

  always_ff @(posedge rx_clk or negedge rx_srst_n) begin
    if (!rx_srst_n) rx_armed <= 1'b0;
    else            rx_armed <= 1'b1;
  end

  always_comb begin
    wr_rise  = wr_n & ~wr_c;
    rd_rise  = rd_n & ~rd_c;
    alm_rise = alm_in & ~alm_c;
  end

  // R1: with ale low, the held address does not move
  p_hold_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (!ale && !$past(ale)) |-> $stable(eff_addr));

  // R3: a qualified write to offset 0 lands in the first control byte
  p_wr_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_rise && !cs_n && eff_addr == '0 && !ale) |=> (ctrl0_q == $past(d_in)));

  // R5: without a read trailing edge no status bit falls
  p_sticky_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (!rd_rise) |=> ((stat & $past(stat)) == $past(stat)));

  // R6: a source rising edge always leaves its bit set, even under a clear
  p_setwin_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (|alm_rise) |=> ((stat & $past(alm_rise)) == $past(alm_rise)));

  // R7: the interrupt stays asserted until a read or a mask write
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_pull && !rd_rise && !wr_rise) |=> irq_pull);

  // R8: the combined alarm follows the sources one receive edge later
  p_rxalm_r8: assert property (@(posedge rx_clk) disable iff (!rx_srst_n)
    rx_armed |-> (rx_alarm == $past(|alm_in)));
endmodule

bind mpbus_alarm_if mpbus_alarm_chk #(.AW(AW), .DW(DW), .NALM(NALM)) u_chk (
  .clk(clk), .srst_n(srst_n), .rx_clk(rx_clk), .rx_srst_n(rx_srst_n),
  .ale(ale), .eff_addr(eff_addr), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .d_in(d_in), .alm_in(alm_in), .stat(stat), .ctrl0_q(ctrl0_q),
  .irq_pull(irq_pull), .rx_alarm(rx_alarm)
);

// File: tb/mpbus_alarm_if_tb.sv
module mpbus_alarm_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RX_HALF    = 7;
  localparam int NVEC       = 14;

  // {is_write, address, data-or-expected}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'hA5}, {1'b0, 8'h00, 8'hA5},
    {1'b1, 8'h01, 8'h3C}, {1'b0, 8'h01, 8'h3C},
    {1'b1, 8'h07, 8'hFF}, {1'b0, 8'h07, 8'h00},
    {1'b0, 8'h00, 8'hA5}, {1'b1, 8'h04, 8'hFF},
    {1'b0, 8'h04, 8'h00}, {1'b0, 8'h02, 8'h00},
    {1'b1, 8'h03, 8'hE5}, {1'b0, 8'h03, 8'h05},
    {1'b1, 8'h03, 8'h00}, {1'b0, 8'h03, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rx_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] addr = '0;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] d_in = '0;
  logic [4:0] alm_in = '0;
  logic [7:0] d_out;
  logic       d_oe;
  logic       irq_pull;
  logic       rx_alarm;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(RX_HALF) rx_clk = ~rx_clk;

  mpbus_alarm_if u_dut (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .ale(ale), .addr(addr),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .d_in(d_in), .d_out(d_out),
    .d_oe(d_oe), .irq_pull(irq_pull), .alm_in(alm_in), .rx_alarm(rx_alarm)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ale = 1'b1; addr = a;
    @(negedge clk); ale = 1'b0; addr = 8'hFF; cs_n = 1'b0; d_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); ale = 1'b1; addr = a;
    @(negedge clk); ale = 1'b0; addr = 8'hFF; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    check("R2 read enable", {7'd0, d_oe}, 8'h01);
    v = d_out;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 d_oe", {7'd0, d_oe}, 8'h00);
    check("R10 irq_pull", {7'd0, irq_pull}, 8'h00);
    check("R10 rx_alarm", {7'd0, rx_alarm}, 8'h00);
    bus_rd(8'h00, rv); check("R10 ctrl0", rv, 8'h00);
    bus_rd(8'h02, rv); check("R10 status", rv, 8'h00);

    // table walk: R3 R4 R9
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][16]) bus_wr(VEC[i][15:8], VEC[i][7:0]);
      else begin
        bus_rd(VEC[i][15:8], rv);
        check($sformatf("R3 R4 R9 table %0d", i), rv, VEC[i][7:0]);
      end
    end

    // R2: no drive with only one of the strobes low
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    check("R2 cs high", {7'd0, d_oe}, 8'h00);
    rd_n = 1'b1; cs_n = 1'b0; #1;
    check("R2 rd high", {7'd0, d_oe}, 8'h00);
    @(negedge clk); cs_n = 1'b1;

    // R3: write strobe with chip select high is ignored
    @(negedge clk); ale = 1'b1; addr = 8'h00;
    @(negedge clk); ale = 1'b0; d_in = 8'h11; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    bus_rd(8'h00, rv); check("R3 no write without cs", rv, 8'hA5);

    // R1: transparent then held
    @(negedge clk); ale = 1'b1; addr = 8'h00; cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R1 transparent a0", d_out, 8'hA5);
    addr = 8'h01; #1;
    check("R1 transparent a1", d_out, 8'h3C);
    @(negedge clk); ale = 1'b0; addr = 8'h00; #1;
    check("R1 held", d_out, 8'h3C);
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;

    // R5 sticky set, R4 live levels, R6 clear on read
    @(negedge clk); alm_in = 5'b00100;
    @(negedge clk);
    bus_rd(8'h02, rv); check("R5 status set", rv, 8'h04);
    bus_rd(8'h04, rv); check("R4 live levels", rv, 8'h04);
    bus_rd(8'h02, rv); check("R6 cleared by read", rv, 8'h00);
    check("R7 masked off", {7'd0, irq_pull}, 8'h00);

    // R7 interrupt vs mask
    bus_wr(8'h03, 8'h04);
    @(negedge clk); alm_in = 5'b00000;
    @(negedge clk); alm_in = 5'b00100;
    @(negedge clk);
    check("R7 irq asserted", {7'd0, irq_pull}, 8'h01);
    bus_wr(8'h03, 8'h08);
    check("R7 other mask bit", {7'd0, irq_pull}, 8'h00);
    bus_rd(8'h02, rv); check("R5 status kept", rv, 8'h04);
    bus_wr(8'h03, 8'h04);
    check("R7 irq after clear", {7'd0, irq_pull}, 8'h00);

    // R6 set on the clearing edge wins
    @(negedge clk); alm_in = 5'b01100;
    @(negedge clk); ale = 1'b1; addr = 8'h02;
    @(negedge clk); ale = 1'b0; addr = 8'hFF; cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R6 read value", d_out, 8'h08);
    @(negedge clk); rd_n = 1'b1; alm_in = 5'b01101;
    @(negedge clk); cs_n = 1'b1;
    bus_rd(8'h02, rv); check("R6 set wins", rv, 8'h01);

    // R8 combined alarm on the receive clock
    @(posedge rx_clk); #1;
    check("R8 high", {7'd0, rx_alarm}, 8'h01);
    alm_in = 5'b00000; #1;
    check("R8 holds between edges", {7'd0, rx_alarm}, 8'h01);
    @(posedge rx_clk); #1;
    check("R8 falls", {7'd0, rx_alarm}, 8'h00);
    alm_in = 5'b10000; #1;
    check("R8 no early rise", {7'd0, rx_alarm}, 8'h00);
    @(posedge rx_clk); #1;
    check("R8 rises", {7'd0, rx_alarm}, 8'h01);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule